// File: doc/BRIEF.md
# Dual-Tone Quadrature Tone Generator

This block synthesizes a stream of in-phase (I) and quadrature (Q) samples containing either one tone or the sum of two tones. Each tone has its own 21-bit phase register, which advances by a programmable step on every clock. The top phase bits address a quarter-wave sine table that produces a sine value (Q) and a cosine value (I). Each value is then multiplied by the tone's gain and truncated back to sample width.

A two-bit mode input selects the behaviour: quiet, one tone, or two tones summed with saturation. The mode, the steps and the gains are set up while the block is quiet and are held constant while it runs. Leaving the quiet mode restarts both phase registers from zero. The first sample appears a fixed three clocks later, flagged by `out_valid`. Typical uses are calibration stimulus for audio signal paths and test tones for modem datapaths.

Top module: `tone_gen_iq`

## Requirements
- R1: `mode` encodes 0 = quiet, 1 = one tone (tone A), 2 = two tones (A + B). The illegal code 3 behaves exactly like quiet.
- R2: After any clock edge at which `mode` is 0 or 3, `out_i` and `out_q` are 0 and `out_valid` is 0.
- R3: Each phase register holds 0 while the block is quiet. It then adds its 21-bit step on every running clock, modulo 2^21, so sample j of a run uses phase (j·step) mod 2^21.
- R4: The amplitude uses p, the top 10 phase bits. With T[i] = round(2047·sin(2π(i+0.5)/1024)) for i in 0..255, S(p) takes magnitude T[p[7:0]], or T[255−p[7:0]] when p[8] is 1, and is negated when p[9] is 1. Q = S(p) and I = S((p+256) mod 1024).
- R5: The scaled tone A sample is floor(amp·gain_a/64), using the 6-bit `gain_a`. The scaled tone B sample is floor(amp·gain_b/32), using the 5-bit `gain_b`. A gain of 0 gives a zero sample.
- R6: In mode 1, `out_i`/`out_q` carry the scaled tone A samples; tone B has no effect.
- R7: In mode 2, `out_i`/`out_q` are the sums of the scaled tone A and tone B samples, saturated to the signed 12-bit range −2048..2047.
- R8: Counting the first clock edge at which the mode is running as edge 1, `out_valid` is low after edges 1 and 2. Sample j is presented after edge 3+j, with `out_valid` high, and `out_valid` stays high while the mode stays running.
- R9: Synchronous active-high `rst` clears the phase registers and the pipeline, so outputs are 0 and `out_valid` is 0 after a reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 0 quiet, 1 one tone, 2 two tones, 3 treated as quiet |
| step_a | input | 21 | Phase increment of tone A |
| step_b | input | 21 | Phase increment of tone B |
| gain_a | input | 6 | Gain of tone A (scaled by 1/64) |
| gain_b | input | 5 | Gain of tone B (scaled by 1/32) |
| out_i | output | 12 | Signed in-phase sample |
| out_q | output | 12 | Signed quadrature sample |
| out_valid | output | 1 | Samples valid |

## Verification
A corrupted phase register moves the sample sequence off its j·step trajectory. This shows on both output streams three clocks after the faulty update, and the error then persists for every later sample. A wrong quadrant fold or table entry appears as a sign flip or a wrong magnitude on the first sample that reaches that part of the wave. Steps of zero, half a turn and almost a full turn drive every quadrant within a few samples. A mistimed pipeline register is exposed by comparing each sample against the clock at which it must appear after leaving the quiet mode. Saturation and shift errors show as soon as a maximum-gain two-tone run starts.

// File: rtl/tg_pkg.sv
package tg_pkg;

    typedef enum logic [1:0] {
        TG_QUIET = 2'd0,
        TG_ONE   = 2'd1,
        TG_TWO   = 2'd2,
        TG_BAD   = 2'd3
    } tg_mode_e;

    // control flags that travel alongside the sample pipeline
    typedef struct packed {
        logic live;
        logic dual;
    } tg_ctl_t;

    function automatic logic tg_running(input logic [1:0] m);
        return (m == TG_ONE) || (m == TG_TWO);
    endfunction

endpackage

// File: rtl/tg_phase_acc.sv
module tg_phase_acc #(
    parameter int PHASE_W = 21
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [PHASE_W-1:0] step,
    output logic [PHASE_W-1:0] phase
);
    always_ff @(posedge clk) begin
        if (rst || !run) phase <= '0;
        else             phase <= phase + step;
    end
endmodule

// File: rtl/tg_quarter_sine.sv
module tg_quarter_sine #(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 12
) (
    input  logic [ADDR_W-1:0]       sin_addr,
    input  logic [ADDR_W-1:0]       cos_addr,
    output logic signed [AMP_W-1:0] sin_val,
    output logic signed [AMP_W-1:0] cos_val
);
    localparam int ENTRIES = 2 ** (ADDR_W - 2);
    localparam int IDX_W   = ADDR_W - 2;
    localparam int MAG_W   = AMP_W - 1;

    logic [MAG_W-1:0] mag_rom [ENTRIES];

    initial begin
        for (int k = 0; k < ENTRIES; k++) begin
            real ang;
            ang = 2.0 * 3.14159265358979323846 * (real'(k) + 0.5) / (4.0 * real'(ENTRIES));
            mag_rom[k] = MAG_W'($rtoi(real'(2 ** MAG_W - 1) * $sin(ang) + 0.5));
        end
    end

    function automatic logic signed [AMP_W-1:0] fold(input logic [ADDR_W-1:0] a);
        logic [IDX_W-1:0] idx;
        logic signed [AMP_W-1:0] mag;
        idx = a[ADDR_W-2] ? ~a[IDX_W-1:0] : a[IDX_W-1:0];
        mag = $signed({1'b0, mag_rom[idx]});
        return a[ADDR_W-1] ? -mag : mag;
    endfunction

    always_comb begin
        sin_val = fold(sin_addr);
        cos_val = fold(cos_addr);
    end
endmodule

// File: rtl/tg_tone_lane.sv
module tg_tone_lane #(
    parameter int PHASE_W = 21,
    parameter int ADDR_W  = 10,
    parameter int AMP_W   = 12,
    parameter int GAIN_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic [PHASE_W-1:0]      step,
    input  logic [GAIN_W-1:0]       gain,
    output logic signed [AMP_W-1:0] scl_i,
    output logic signed [AMP_W-1:0] scl_q
);
    localparam int PROD_W = AMP_W + GAIN_W + 1;
    localparam int QTR    = 2 ** (ADDR_W - 2);

    logic [PHASE_W-1:0]      phase;
    logic [ADDR_W-1:0]       addr_s, addr_c;
    logic signed [AMP_W-1:0] lut_s, lut_c;
    logic signed [AMP_W-1:0] amp_i, amp_q;
    logic signed [PROD_W-1:0] prod_i, prod_q, gain_s;

    tg_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk(clk), .rst(rst), .run(run), .step(step), .phase(phase)
    );

    assign addr_s = phase[PHASE_W-1 -: ADDR_W];
    assign addr_c = addr_s + ADDR_W'(QTR);

    tg_quarter_sine #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
        .sin_addr(addr_s), .cos_addr(addr_c), .sin_val(lut_s), .cos_val(lut_c)
    );

    // stage 1: amplitude lookup
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            amp_i <= '0;
            amp_q <= '0;
        end else begin
            amp_i <= lut_c;
            amp_q <= lut_s;
        end
    end

    always_comb begin
        gain_s = PROD_W'($signed({1'b0, gain}));
        prod_i = PROD_W'(amp_i) * gain_s;
        prod_q = PROD_W'(amp_q) * gain_s;
    end

    // stage 2: gain and truncation (shift equals gain width)
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            scl_i <= '0;
            scl_q <= '0;
        end else begin
            scl_i <= AMP_W'(prod_i >>> GAIN_W);
            scl_q <= AMP_W'(prod_q >>> GAIN_W);
        end
    end
endmodule

// File: rtl/tone_gen_iq.sv
module tone_gen_iq
    import tg_pkg::*;
#(
    parameter int PHASE_W  = 21,
    parameter int ADDR_W   = 10,
    parameter int AMP_W    = 12,
    parameter int GAIN_A_W = 6,
    parameter int GAIN_B_W = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              mode,
    input  logic [PHASE_W-1:0]      step_a,
    input  logic [PHASE_W-1:0]      step_b,
    input  logic [GAIN_A_W-1:0]     gain_a,
    input  logic [GAIN_B_W-1:0]     gain_b,
    output logic signed [AMP_W-1:0] out_i,
    output logic signed [AMP_W-1:0] out_q,
    output logic                    out_valid
);
    logic run;
    logic signed [AMP_W-1:0] a_i, a_q, b_i, b_q;
    tg_ctl_t ctl_s1, ctl_s2;

    assign run = tg_running(mode);

    tg_tone_lane #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W), .GAIN_W(GAIN_A_W)) u_lane_a (
        .clk(clk), .rst(rst), .run(run), .step(step_a), .gain(gain_a), .scl_i(a_i), .scl_q(a_q)
    );

    tg_tone_lane #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W), .GAIN_W(GAIN_B_W)) u_lane_b (
        .clk(clk), .rst(rst), .run(run), .step(step_b), .gain(gain_b), .scl_i(b_i), .scl_q(b_q)
    );

    function automatic logic signed [AMP_W-1:0] sat_add(input logic signed [AMP_W-1:0] x,
                                                        input logic signed [AMP_W-1:0] y);
        logic signed [AMP_W:0] s;
        s = {x[AMP_W-1], x} + {y[AMP_W-1], y};
        if (s[AMP_W] != s[AMP_W-1])
            return s[AMP_W] ? {1'b1, {(AMP_W-1){1'b0}}} : {1'b0, {(AMP_W-1){1'b1}}};
        return s[AMP_W-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ctl_s1 <= '0;
            ctl_s2 <= '0;
        end else begin
            ctl_s1 <= '{live: 1'b1, dual: (mode == TG_TWO)};
            ctl_s2 <= ctl_s1;
        end
    end

    // stage 3: tone combination
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            out_i     <= '0;
            out_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= ctl_s2.live;
            out_i     <= ctl_s2.dual ? sat_add(a_i, b_i) : a_i;
            out_q     <= ctl_s2.dual ? sat_add(a_q, b_q) : a_q;
        end
    end
endmodule

// File: rtl/tg_checks.sv
module tg_checks #(
    parameter int AMP_W = 12
) (
    input logic                    clk,
    input logic                    rst,
    input logic [1:0]              mode,
    input logic signed [AMP_W-1:0] out_i,
    input logic signed [AMP_W-1:0] out_q,
    input logic                    out_valid
);
    logic run;
    assign run = (mode == 2'd1) || (mode == 2'd2);

    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
        !run |=> (out_i == '0 && out_q == '0 && !out_valid)); // R2

    AST_FILL_DELAY: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> ($past(run, 1) && $past(run, 2) && $past(run, 3))); // R8

    AST_VALID_KEEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && run) |=> out_valid); // R8

    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(run)); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (out_i == '0 && out_q == '0 && !out_valid)); // R9
endmodule

bind tone_gen_iq tg_checks #(.AMP_W(AMP_W)) u_checks (
    .clk(clk), .rst(rst), .mode(mode), .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
);

// File: tb/tb_tone_gen_iq.sv
module tb_tone_gen_iq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic [20:0] step_a = '0, step_b = '0;
    logic [5:0]  gain_a = '0;
    logic [4:0]  gain_b = '0;
    logic signed [11:0] out_i, out_q;
    logic        out_valid;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int qtab [256];

    tone_gen_iq dut (
        .clk(clk), .rst(rst), .mode(mode), .step_a(step_a), .step_b(step_b),
        .gain_a(gain_a), .gain_b(gain_b), .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic int wave(int p10);
        int q = (p10 >> 8) & 3;
        int i = p10 & 255;
        int m;
        if (q & 1) i = 255 - i;
        m = qtab[i];
        return (q & 2) ? -m : m;
    endfunction

    function automatic int tone(int step, int j, int g, int sh, bit cosine);
        longint ph = (longint'(j) * longint'(step)) % 64'sd2097152;
        int p10 = int'(ph >> 11);
        if (cosine) p10 = (p10 + 256) & 1023;
        return (wave(p10) * g) >>> sh;
    endfunction

    function automatic int sat12(int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    task automatic check(string tag, int ei, int eq, bit ev);
        int ai = int'(out_i);
        int aq = int'(out_q);
        checks++;
        if (ai != ei || aq != eq || out_valid !== ev) begin
            fails++;
            $display("FAIL %s: actual i=%0d q=%0d v=%0b, expected i=%0d q=%0d v=%0b",
                     tag, ai, aq, out_valid, ei, eq, ev);
        end
    endtask

    task automatic run_case(string tag, logic [1:0] m, int sa, int sb, int ga, int gb, int ncyc);
        bit running = (m == 2'd1) || (m == 2'd2);
        @(negedge clk);
        mode = 2'd0; step_a = 21'(sa); step_b = 21'(sb); gain_a = 6'(ga); gain_b = 5'(gb);
        @(negedge clk);
        mode = m;
        for (int n = 1; n <= ncyc; n++) begin
            @(negedge clk);
            if (!running) check({tag, " R1 illegal/quiet"}, 0, 0, 1'b0);
            else if (n < 3) check({tag, " R8 fill"}, 0, 0, 1'b0);
            else begin
                int j = n - 3;
                int ei = tone(sa, j, ga, 6, 1'b1);
                int eq = tone(sa, j, ga, 6, 1'b0);
                if (m == 2'd2) begin
                    ei = sat12(ei + tone(sb, j, gb, 5, 1'b1));
                    eq = sat12(eq + tone(sb, j, gb, 5, 1'b0));
                    check({tag, " R7"}, ei, eq, 1'b1);
                end else check({tag, " R6"}, ei, eq, 1'b1);
            end
        end
        mode = 2'd0;
        @(negedge clk);
        check({tag, " R2 back to quiet"}, 0, 0, 1'b0);
    endtask

    initial begin
        for (int k = 0; k < 256; k++)
            qtab[k] = $rtoi(2047.0 * $sin(2.0 * 3.14159265358979323846 * (real'(k) + 0.5) / 1024.0) + 0.5);
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R9 reset state", 0, 0, 1'b0);
        rst = 1'b0;

        run_case("R4 zero step", 2'd1, 0, 0, 63, 0, 8);
        run_case("R4 quadrants", 2'd1, 21'h080000, 0, 63, 0, 12);
        run_case("R4 half turn", 2'd1, 21'h100000, 0, 40, 0, 10);
        run_case("R3 wrap", 2'd1, 21'h1FFFFF, 0, 63, 0, 12);
        run_case("R3 fine step", 2'd1, 12345, 0, 17, 0, 30);
        run_case("R5 gain zero", 2'd1, 3000, 0, 0, 31, 10);
        run_case("R6 tone B ignored", 2'd1, 50000, 21'h155555, 33, 31, 16);
        run_case("R7 saturation", 2'd2, 0, 0, 63, 31, 8);
        run_case("R7 neg saturation", 2'd2, 21'h100000, 21'h100000, 63, 31, 8);
        run_case("R7 mixed", 2'd2, 77777, 21'h0A0000, 20, 9, 30);
        run_case("R1 mode three", 2'd3, 9999, 8888, 63, 31, 8);

        for (int r = 0; r < 14; r++) begin
            logic [1:0] m = ($urandom() & 1) ? 2'd2 : 2'd1;
            run_case("R5 random", m, int'($urandom() & 21'h1FFFFF), int'($urandom() & 21'h1FFFFF),
                     int'($urandom() & 63), int'($urandom() & 31), 25);
        end

        // reset in the middle of a run
        @(negedge clk);
        step_a = 21'd4096; gain_a = 6'd50; mode = 2'd1;
        repeat (6) @(negedge clk);
        check("R8 running before reset", tone(4096, 3, 50, 6, 1'b1), tone(4096, 3, 50, 6, 1'b0), 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset mid-run", 0, 0, 1'b0);
        rst = 1'b0;
        for (int n = 1; n <= 4; n++) begin
            @(negedge clk);
            if (n < 3) check("R8 refill after reset", 0, 0, 1'b0);
            else check("R3 restart from zero", tone(4096, n - 3, 50, 6, 1'b1), tone(4096, n - 3, 50, 6, 1'b0), 1'b1);
        end
        mode = 2'd0;
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule